// File: doc/BRIEF.md
# Power-Up Start Vector Selector

After reset this block works out where the processor starts and with which status word. It takes a two-bit mode from board straps, four high-order address straps and one halt-handling strap. In the low-memory mode it fetches the start PC and PS over a simple read port. In the other modes it forms them directly or sends the processor into its built-in debug monitor. When the values are final it raises a one-cycle start pulse. From that pulse on it holds the start PC, the start PS, a monitor-entry request and a flag that says whether pending interrupts may be taken.

The straps are read once, on the first clock after reset is released. They are ignored from then until the next reset. The halt-handling strap is not latched. It goes straight to a static control output for the execution core.

Top module: `start_vector_sel`

## Requirements
- R1: The mode is `strap_mode` read as a raw two-bit number, where an installed strap reads 0. Bit 1 is the first strap and bit 0 is the second. 0 selects low-memory fetch, 1 selects the monitor, 2 selects the ROM entry and 3 selects the strap address.
- R2: In mode 0 the block reads octal address 24 first and octal address 26 second. The first read's data becomes the start PC and the second read's data becomes the start PS. `irq_allow` is 1 and `monitor_req` is 0.
- R3: In mode 1 the block issues no read. It presents PC 0 and PS 0 with `monitor_req` 1 and `irq_allow` 0.
- R4: In mode 2 the start PC is octal 173000 and the start PS is octal 340, with `irq_allow` 1 and no read.
- R5: In mode 3 the start PC has bits 15:12 equal to `strap_addr` and bits 11:0 zero. The start PS is octal 340, `irq_allow` is 1 and no read is issued.
- R6: If either mode-0 read returns with `rd_timeout` high, no further read is made. The start PC is then the address that failed (24 or 26), the PS is 0, `monitor_req` is 1 and `irq_allow` is 0.
- R7: `start_pulse` is high for exactly one clock per reset. It rises only after every read the mode needs has completed.
- R8: The mode and address straps are captured on the first clock after reset release. Changes to them later have no effect until the next reset.
- R9: `halt_trap` follows `strap_halt` at all times. A 1 means a HALT instruction traps to location 4, and a 0 means it enters the monitor.
- R10: Before the start pulse, `start_pc`, `start_ps`, `monitor_req` and `irq_allow` are all 0. From the pulse onward they hold constant until reset.
- R11: `rd_req` stays high with an unchanging `rd_addr` until the cycle in which `rd_done` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| strap_mode | input | 2 | Raw mode straps, installed reads 0 |
| strap_addr | input | 4 | Start address bits 15:12 for mode 3 |
| strap_halt | input | 1 | HALT handling strap |
| rd_req | output | 1 | Read request, held until done |
| rd_addr | output | 16 | Read word address |
| rd_done | input | 1 | Read response strobe |
| rd_data | input | 16 | Read data, valid with rd_done |
| rd_timeout | input | 1 | Read timed out, valid with rd_done |
| start_pulse | output | 1 | One-cycle start indication |
| start_pc | output | 16 | Start program counter |
| start_ps | output | 16 | Start processor status |
| monitor_req | output | 1 | Enter debug monitor |
| irq_allow | output | 1 | Pending interrupts may be honoured |
| halt_trap | output | 1 | HALT traps to location 4 when 1 |

## Verification
The hardest case to reach is a timeout on the second low-memory read after the first read has already succeeded. In that case the PC must report address 26 and not the data the first read captured. The bench memory model answers by address, with a timeout flag and a latency set for each vector. This lets one table entry make the first read good and the second one fail, at a different response delay from the other low-memory entries. Strap changes made after the start pulse are checked by watching that the held outputs stay unchanged and that no second pulse appears.

// File: rtl/svs_pkg.sv
`timescale 1ns/1ps
package svs_pkg;
  localparam int WORD_W = 16;
  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    MODE_LOWMEM  = 2'd0,
    MODE_MONITOR = 2'd1,
    MODE_ROM     = 2'd2,
    MODE_STRAP   = 2'd3
  } start_mode_e;

  typedef enum logic [2:0] {
    SEQ_SAMPLE, SEQ_DECIDE, SEQ_FETCH, SEQ_START, SEQ_RUN
  } seq_state_e;

  typedef enum logic [1:0] {
    FET_IDLE, FET_PC, FET_PS
  } fetch_state_e;

  // raw strap pair read as a number, installed = 0
  function automatic start_mode_e decode_mode(input logic [1:0] raw);
    return start_mode_e'(raw);
  endfunction

  // high-order straps placed at the top of the word, rest zero
  function automatic word_t strap_entry(input word_t hi_bits, input int n_bits);
    return word_t'(hi_bits << (WORD_W - n_bits));
  endfunction
endpackage

// File: rtl/svs_strap_latch.sv
`timescale 1ns/1ps
module svs_strap_latch
  import svs_pkg::*;
#(
  parameter int N_ADDR = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [1:0]        mode_raw,
  input  logic [N_ADDR-1:0] addr_raw,
  output start_mode_e       mode_q,
  output logic [N_ADDR-1:0] addr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_LOWMEM;
      addr_q <= '0;
    end else if (capture) begin
      mode_q <= decode_mode(mode_raw);
      addr_q <= addr_raw;
    end
  end
endmodule

// File: rtl/svs_vec_fetch.sv
`timescale 1ns/1ps
module svs_vec_fetch
  import svs_pkg::*;
#(
  parameter word_t PC_ADDR = 16'o24,
  parameter word_t PS_ADDR = 16'o26
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  go,
  output logic  rd_req,
  output word_t rd_addr,
  input  logic  rd_done,
  input  word_t rd_data,
  input  logic  rd_timeout,
  output logic  done,
  output logic  failed,
  output word_t fail_addr,
  output word_t pc_word,
  output word_t ps_word
);
  fetch_state_e state;

  assign rd_req  = (state != FET_IDLE);
  assign rd_addr = (state == FET_PS) ? PS_ADDR : PC_ADDR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= FET_IDLE;
      done      <= 1'b0;
      failed    <= 1'b0;
      fail_addr <= '0;
      pc_word   <= '0;
      ps_word   <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        FET_IDLE: if (go) state <= FET_PC;
        FET_PC: if (rd_done) begin
          if (rd_timeout) begin
            failed    <= 1'b1;
            fail_addr <= PC_ADDR;
            done      <= 1'b1;
            state     <= FET_IDLE;
          end else begin
            pc_word <= rd_data;
            state   <= FET_PS;
          end
        end
        FET_PS: if (rd_done) begin
          if (rd_timeout) begin
            failed    <= 1'b1;
            fail_addr <= PS_ADDR;
          end else begin
            ps_word <= rd_data;
          end
          done  <= 1'b1;
          state <= FET_IDLE;
        end
        default: state <= FET_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/start_vector_sel.sv
`timescale 1ns/1ps
module start_vector_sel
  import svs_pkg::*;
#(
  parameter word_t PC_VEC_ADDR  = 16'o24,
  parameter word_t PS_VEC_ADDR  = 16'o26,
  parameter word_t ROM_ENTRY    = 16'o173000,
  parameter word_t BOOT_PS      = 16'o340,
  parameter int    N_ADDR_STRAPS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               strap_mode,
  input  logic [N_ADDR_STRAPS-1:0] strap_addr,
  input  logic                     strap_halt,
  output logic                     rd_req,
  output logic [WORD_W-1:0]        rd_addr,
  input  logic                     rd_done,
  input  logic [WORD_W-1:0]        rd_data,
  input  logic                     rd_timeout,
  output logic                     start_pulse,
  output logic [WORD_W-1:0]        start_pc,
  output logic [WORD_W-1:0]        start_ps,
  output logic                     monitor_req,
  output logic                     irq_allow,
  output logic                     halt_trap
);
  seq_state_e                state;
  start_mode_e               mode_q;
  logic [N_ADDR_STRAPS-1:0]  addr_q;
  logic                      sample_now;
  logic                      fetch_go;
  logic                      fetch_done;
  logic                      fetch_failed;
  word_t                     fetch_fail_addr;
  word_t                     fetch_pc;
  word_t                     fetch_ps;
  logic                      running;

  assign sample_now  = (state == SEQ_SAMPLE);
  assign fetch_go    = (state == SEQ_DECIDE) && (mode_q == MODE_LOWMEM);
  assign start_pulse = (state == SEQ_START);
  assign running     = (state == SEQ_RUN);
  assign halt_trap   = strap_halt;

  svs_strap_latch #(.N_ADDR(N_ADDR_STRAPS)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (sample_now),
    .mode_raw (strap_mode),
    .addr_raw (strap_addr),
    .mode_q   (mode_q),
    .addr_q   (addr_q)
  );

  svs_vec_fetch #(.PC_ADDR(PC_VEC_ADDR), .PS_ADDR(PS_VEC_ADDR)) u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (fetch_go),
    .rd_req     (rd_req),
    .rd_addr    (rd_addr),
    .rd_done    (rd_done),
    .rd_data    (rd_data),
    .rd_timeout (rd_timeout),
    .done       (fetch_done),
    .failed     (fetch_failed),
    .fail_addr  (fetch_fail_addr),
    .pc_word    (fetch_pc),
    .ps_word    (fetch_ps)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= SEQ_SAMPLE;
      start_pc    <= '0;
      start_ps    <= '0;
      monitor_req <= 1'b0;
      irq_allow   <= 1'b0;
    end else begin
      case (state)
        SEQ_SAMPLE: state <= SEQ_DECIDE;
        SEQ_DECIDE: begin
          case (mode_q)
            MODE_LOWMEM: state <= SEQ_FETCH;
            MODE_MONITOR: begin
              start_pc    <= '0;
              start_ps    <= '0;
              monitor_req <= 1'b1;
              irq_allow   <= 1'b0;
              state       <= SEQ_START;
            end
            MODE_ROM: begin
              start_pc  <= ROM_ENTRY;
              start_ps  <= BOOT_PS;
              irq_allow <= 1'b1;
              state     <= SEQ_START;
            end
            MODE_STRAP: begin
              start_pc  <= strap_entry(word_t'(addr_q), N_ADDR_STRAPS);
              start_ps  <= BOOT_PS;
              irq_allow <= 1'b1;
              state     <= SEQ_START;
            end
          endcase
        end
        SEQ_FETCH: if (fetch_done) begin
          if (fetch_failed) begin
            start_pc    <= fetch_fail_addr;
            start_ps    <= '0;
            monitor_req <= 1'b1;
            irq_allow   <= 1'b0;
          end else begin
            start_pc  <= fetch_pc;
            start_ps  <= fetch_ps;
            irq_allow <= 1'b1;
          end
          state <= SEQ_START;
        end
        SEQ_START: state <= SEQ_RUN;
        SEQ_RUN:   state <= SEQ_RUN;
        default:   state <= SEQ_SAMPLE;
      endcase
    end
  end
endmodule

// File: rtl/svs_checker.sv
`timescale 1ns/1ps
module svs_checker #(
  parameter logic [15:0] ROM_ENTRY = 16'o173000,
  parameter logic [15:0] BOOT_PS   = 16'o340
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start_pulse,
  input logic [15:0] start_pc,
  input logic [15:0] start_ps,
  input logic        monitor_req,
  input logic        irq_allow,
  input logic        rd_req,
  input logic [15:0] rd_addr,
  input logic        rd_done,
  input logic        rd_timeout,
  input logic [1:0]  mode_q,
  input logic        running
);
  assert_one_wide_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);

  assert_no_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != 2'd0) |-> !rd_req);

  assert_addr_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_done) |=> (rd_req && $stable(rd_addr)));

  assert_stop_after_timeout_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_done && rd_timeout) |=> !rd_req);

  assert_monitor_ps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pulse && monitor_req) |-> (start_ps == 16'd0 && !irq_allow));

  assert_irq_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> (irq_allow != monitor_req));

  assert_rom_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pulse && mode_q == 2'd2) |-> (start_pc == ROM_ENTRY && start_ps == BOOT_PS));

  assert_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> ($stable(start_pc) && $stable(start_ps) && $stable(monitor_req)
                 && $stable(irq_allow)));
endmodule

bind start_vector_sel svs_checker #(.ROM_ENTRY(ROM_ENTRY), .BOOT_PS(BOOT_PS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_pulse (start_pulse),
  .start_pc    (start_pc),
  .start_ps    (start_ps),
  .monitor_req (monitor_req),
  .irq_allow   (irq_allow),
  .rd_req      (rd_req),
  .rd_addr     (rd_addr),
  .rd_done     (rd_done),
  .rd_timeout  (rd_timeout),
  .mode_q      (mode_q),
  .running     (running)
);

// File: tb/start_vector_sel_test.sv
`timescale 1ns/1ps
module start_vector_sel_test;
  typedef struct packed {
    logic [1:0]  mode;
    logic [3:0]  addr;
    logic [1:0]  lat;
    logic        to_pc;
    logic        to_ps;
    logic [15:0] d_pc;
    logic [15:0] d_ps;
    logic [15:0] e_pc;
    logic [15:0] e_ps;
    logic        e_mon;
    logic        e_irq;
    logic [1:0]  e_reads;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 4'h0, 2'd0, 1'b0, 1'b0, 16'o1000,   16'o340, 16'o1000,   16'o340, 1'b0, 1'b1, 2'd2},
    '{2'd0, 4'h3, 2'd3, 1'b0, 1'b0, 16'o157776, 16'o17,  16'o157776, 16'o17,  1'b0, 1'b1, 2'd2},
    '{2'd0, 4'h0, 2'd1, 1'b1, 1'b0, 16'o4444,   16'o340, 16'o24,     16'o0,   1'b1, 1'b0, 2'd1},
    '{2'd0, 4'h0, 2'd2, 1'b0, 1'b1, 16'o2222,   16'o340, 16'o26,     16'o0,   1'b1, 1'b0, 2'd2},
    '{2'd1, 4'h5, 2'd0, 1'b0, 1'b0, 16'o7777,   16'o7,   16'o0,      16'o0,   1'b1, 1'b0, 2'd0},
    '{2'd2, 4'h9, 2'd0, 1'b0, 1'b0, 16'o7777,   16'o7,   16'o173000, 16'o340, 1'b0, 1'b1, 2'd0},
    '{2'd3, 4'hA, 2'd0, 1'b0, 1'b0, 16'o7777,   16'o7,   16'hA000,   16'o340, 1'b0, 1'b1, 2'd0},
    '{2'd3, 4'hF, 2'd0, 1'b0, 1'b0, 16'o7777,   16'o7,   16'hF000,   16'o340, 1'b0, 1'b1, 2'd0},
    '{2'd3, 4'h0, 2'd0, 1'b0, 1'b0, 16'o7777,   16'o7,   16'h0000,   16'o340, 1'b0, 1'b1, 2'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  strap_mode = 2'd0;
  logic [3:0]  strap_addr = 4'd0;
  logic        strap_halt = 1'b0;
  logic        rd_req;
  logic [15:0] rd_addr;
  logic        rd_done = 1'b0;
  logic [15:0] rd_data = 16'd0;
  logic        rd_timeout = 1'b0;
  logic        start_pulse;
  logic [15:0] start_pc;
  logic [15:0] start_ps;
  logic        monitor_req;
  logic        irq_allow;
  logic        halt_trap;

  int checks = 0;
  int errors = 0;
  vec_t cur;
  int lat_cnt = 0;
  int reads_seen = 0;
  int pulse_cnt = 0;
  logic [15:0] log_a, log_b;

  always #2.5 clk = ~clk;

  start_vector_sel uut (
    .clk(clk), .rst_n(rst_n), .strap_mode(strap_mode), .strap_addr(strap_addr),
    .strap_halt(strap_halt), .rd_req(rd_req), .rd_addr(rd_addr), .rd_done(rd_done),
    .rd_data(rd_data), .rd_timeout(rd_timeout), .start_pulse(start_pulse),
    .start_pc(start_pc), .start_ps(start_ps), .monitor_req(monitor_req),
    .irq_allow(irq_allow), .halt_trap(halt_trap)
  );

  // memory model: answers by address after cur.lat waiting cycles
  always @(negedge clk) begin
    if (!rst_n) begin
      rd_done = 1'b0; lat_cnt = 0;
    end else if (rd_done) begin
      rd_done = 1'b0; rd_timeout = 1'b0;
    end else if (rd_req) begin
      if (lat_cnt >= int'(cur.lat)) begin
        lat_cnt = 0;
        if (reads_seen == 0) log_a = rd_addr; else log_b = rd_addr;
        reads_seen++;
        rd_done = 1'b1;
        if (rd_addr == 16'o24) begin rd_data = cur.d_pc; rd_timeout = cur.to_pc; end
        else begin rd_data = cur.d_ps; rd_timeout = cur.to_ps; end
      end else lat_cnt++;
    end
    if (rst_n && start_pulse) pulse_cnt++;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0o expected=%0o", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_vec(input vec_t v);
    string req;
    int n;
    req = (v.mode == 2'd0) ? (v.e_mon ? "R6" : "R2") :
          (v.mode == 2'd1) ? "R3" : (v.mode == 2'd2) ? "R4" : "R5";
    cur = v; strap_mode = v.mode; strap_addr = v.addr;
    reads_seen = 0; log_a = '0; log_b = '0;
    do_reset();
    pulse_cnt = 0;
    @(negedge clk);
    check(start_pc == 0 && start_ps == 0 && !monitor_req && !irq_allow, "R10",
          "outputs before start", {start_pc, start_ps}, 32'd0);
    n = 0;
    while (!start_pulse && n < 100) begin @(negedge clk); n++; end
    check(start_pulse == 1'b1, "R7", "start pulse seen", 32'(start_pulse), 32'd1);
    check(start_pc == v.e_pc, "R1", {req, " start_pc"}, 32'(start_pc), 32'(v.e_pc));
    check(start_ps == v.e_ps, req, "start_ps", 32'(start_ps), 32'(v.e_ps));
    check(monitor_req == v.e_mon, req, "monitor_req", 32'(monitor_req), 32'(v.e_mon));
    check(irq_allow == v.e_irq, req, "irq_allow", 32'(irq_allow), 32'(v.e_irq));
    check(reads_seen == int'(v.e_reads), "R7", "reads completed at pulse",
          32'(reads_seen), 32'(v.e_reads));
    if (v.e_reads >= 2'd1)
      check(log_a == 16'o24, "R2", "first read address", 32'(log_a), 32'o24);
    if (v.e_reads == 2'd2)
      check(log_b == 16'o26, "R2", "second read address", 32'(log_b), 32'o26);
    @(negedge clk);
    check(!start_pulse, "R7", "pulse one cycle", 32'(start_pulse), 32'd0);
    repeat (4) @(negedge clk);
    check(pulse_cnt == 1, "R7", "pulses per reset", 32'(pulse_cnt), 32'd1);
    check(!rd_req, "R11", "no request after start", 32'(rd_req), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cur = VECS[0];
    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R8: straps changed after start are ignored
    run_vec(VECS[5]);
    strap_mode = 2'd3; strap_addr = 4'h7;
    repeat (6) @(negedge clk);
    check(start_pc == 16'o173000, "R8", "pc after strap change", 32'(start_pc), 32'o173000);
    check(start_ps == 16'o340, "R8", "ps after strap change", 32'(start_ps), 32'o340);
    check(pulse_cnt == 1, "R8", "no new pulse after strap change", 32'(pulse_cnt), 32'd1);
    // R8: a new reset picks up the new straps
    cur = VECS[6]; strap_mode = 2'd3; strap_addr = 4'h7;
    do_reset();
    repeat (6) @(negedge clk);
    check(start_pc == 16'h7000, "R8", "pc after new reset", 32'(start_pc), 32'h7000);

    // R9: halt strap passes straight through
    strap_halt = 1'b1; #1;
    check(halt_trap == 1'b1, "R9", "halt_trap high", 32'(halt_trap), 32'd1);
    strap_halt = 1'b0; #1;
    check(halt_trap == 1'b0, "R9", "halt_trap low", 32'(halt_trap), 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule